// File: doc/BRIEF.md
# Sound Onset Detector

This block sits on an 8-bit audio sample stream (nominally 5 kHz, unsigned, mid-scale 128 meaning silence) and finds where a spoken word starts. It sums the distance of each sample from mid-scale over consecutive, non-overlapping windows of 2^WIN_LOG2 samples. The mean of each window is its sum shifted right by WIN_LOG2. When a window's mean beats the mean of the window just before it by more than a programmable threshold, the block flags an onset.

The onset is placed at the first sample of the louder window. A delay line one window deep lets the block emit exactly CAPTURE_LEN samples downstream starting from that sample. The defaults are 1024-sample windows and 5120 samples, about 1.024 s at 5 kHz. While a word is being captured, detection is paused. After the last captured sample a done strobe fires and the block re-arms. It must then collect two fresh windows before it can detect again.

Top module: `onset_detector`

## Requirements
- R1: A sample s has amplitude |s - 128| (0 to 128). A window mean is the window's amplitude sum shifted right by WIN_LOG2, so fractions are dropped.
- R2: After reset, and again after each capture ends, no onset is flagged until two complete windows have been gathered.
- R3: An onset is flagged only when the later window's mean minus the earlier window's mean is strictly greater than `threshold`. An equal difference, or a falling level, flags nothing.
- R4: Windows follow one another without overlap. Each new window starts right after the previous one ends, and only window-boundary means are compared.
- R5: `onset_pulse` is high for exactly one cycle: the cycle after the edge that accepts the last sample of the louder window.
- R6: During capture, each accepted sample yields `word_valid` high in the next cycle. `word_sample` then carries the input from one window earlier, so the first word sample is the first sample of the louder window. `word_sample` is 0 whenever `word_valid` is low.
- R7: A capture delivers exactly CAPTURE_LEN word samples. `capture_done` is high for one cycle, together with the last `word_valid`.
- R8: Input level changes during a capture flag no onset. After re-arming, detection uses only windows that start after the capture ended.
- R9: A cycle without `sample_valid` changes no state, and the next cycle has all three strobes low.
- R10: While reset is held, and in the first cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_in | input | SAMPLE_W | Unsigned audio sample, mid-scale is silence |
| sample_valid | input | 1 | `sample_in` is accepted on this edge |
| threshold | input | THR_W | Minimum rise in window mean, exclusive |
| onset_pulse | output | 1 | One-cycle onset flag |
| word_sample | output | SAMPLE_W | Captured sample, 0 when not valid |
| word_valid | output | 1 | `word_sample` carries a captured sample |
| capture_done | output | 1 | Last captured sample is on the output |

## Verification
The assertions take for granted that `sample_valid` is low while reset is held. They also assume that `threshold` changes only between windows, so one window-end comparison never sees two threshold values. The bench drives samples on falling edges and holds `sample_valid` low throughout reset. It changes `threshold` only between scripted scenarios and sweep passes. It also inserts idle cycles between samples so that the hold-state behaviour is exercised. It uses 8-sample windows and 20-sample captures, which lets a long pseudo-random sweep reach many onsets, captures and re-arms.

// File: rtl/onset_pkg.sv
package onset_pkg;
   typedef enum logic {
      MODE_ARMED   = 1'b0,
      MODE_CAPTURE = 1'b1
   } onset_mode_t;

   function automatic int unsigned max_int(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/onset_magnitude.sv
module onset_magnitude #(
   parameter int SAMPLE_W = 8
) (
   input  logic [SAMPLE_W-1:0] sample,
   output logic [SAMPLE_W-1:0] mag
);
   localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1) << (SAMPLE_W - 1);

   always_comb begin
      if (sample >= MID) mag = sample - MID;
      else               mag = MID - sample;
   end
endmodule

// File: rtl/onset_window_mean.sv
module onset_window_mean #(
   parameter int MAG_W    = 8,
   parameter int WIN_LOG2 = 10,
   parameter int THR_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [MAG_W-1:0] mag,
   input  logic [THR_W-1:0] thr,
   output logic             jump
);
   localparam int SUM_W = MAG_W + WIN_LOG2;
   localparam int CMP_W = onset_pkg::max_int(MAG_W, THR_W);

   logic [WIN_LOG2-1:0] phase;
   logic [SUM_W-1:0]    sum;
   logic [SUM_W-1:0]    sum_next;
   logic [MAG_W-1:0]    prev_mean;
   logic [MAG_W-1:0]    cur_mean;
   logic [CMP_W-1:0]    rise;
   logic                have_prev;
   logic                last;

   always_comb begin
      sum_next = sum + SUM_W'(mag);
      last     = (phase == {WIN_LOG2{1'b1}});
      cur_mean = sum_next[SUM_W-1:WIN_LOG2];
      rise     = CMP_W'(cur_mean - prev_mean);
      jump     = en && last && have_prev && (cur_mean > prev_mean) && (rise > CMP_W'(thr));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= '0;
         sum       <= '0;
         prev_mean <= '0;
         have_prev <= 1'b0;
      end else if (en) begin
         if (last) begin
            sum   <= '0;
            phase <= '0;
            if (jump) begin
               have_prev <= 1'b0;
               prev_mean <= '0;
            end else begin
               have_prev <= 1'b1;
               prev_mean <= cur_mean;
            end
         end else begin
            sum   <= sum_next;
            phase <= phase + 1'b1;
         end
      end
   end
endmodule

// File: rtl/onset_delay_line.sv
module onset_delay_line #(
   parameter int DATA_W     = 8,
   parameter int DEPTH_LOG2 = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int DEPTH = 1 << DEPTH_LOG2;

   logic [DATA_W-1:0]     mem [DEPTH];
   logic [DEPTH_LOG2-1:0] wp;

   assign dout = mem[wp];

   always_ff @(posedge clk) begin
      if (!rst_n)    wp <= '0;
      else if (push) wp <= wp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end
endmodule

// File: rtl/onset_capture.sv
module onset_capture #(
   parameter int DATA_W      = 8,
   parameter int CAPTURE_LEN = 5120
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              step,
   input  logic [DATA_W-1:0] din,
   output logic              active,
   output logic              word_valid,
   output logic [DATA_W-1:0] word_sample,
   output logic              done
);
   import onset_pkg::*;

   localparam int CNT_W = $clog2(CAPTURE_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CAPTURE_LEN - 1);

   onset_mode_t      mode;
   logic [CNT_W-1:0] cnt;

   assign active = (mode == MODE_CAPTURE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode        <= MODE_ARMED;
         cnt         <= '0;
         word_valid  <= 1'b0;
         word_sample <= '0;
         done        <= 1'b0;
      end else begin
         word_valid  <= 1'b0;
         word_sample <= '0;
         done        <= 1'b0;
         if (start && !active) begin
            mode <= MODE_CAPTURE;
            cnt  <= '0;
         end else if (active && step) begin
            word_valid  <= 1'b1;
            word_sample <= din;
            if (cnt == LAST) begin
               mode <= MODE_ARMED;
               done <= 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/onset_detector.sv
module onset_detector #(
   parameter int SAMPLE_W    = 8,
   parameter int THR_W       = 8,
   parameter int WIN_LOG2    = 10,
   parameter int CAPTURE_LEN = 5120
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                sample_valid,
   input  logic [THR_W-1:0]    threshold,
   output logic                onset_pulse,
   output logic [SAMPLE_W-1:0] word_sample,
   output logic                word_valid,
   output logic                capture_done
);
   initial begin
      if (SAMPLE_W < 2)    $error("SAMPLE_W must be at least 2");
      if (THR_W < 1)       $error("THR_W must be at least 1");
      if (WIN_LOG2 < 1)    $error("WIN_LOG2 must be at least 1");
      if (CAPTURE_LEN < 2) $error("CAPTURE_LEN must be at least 2");
   end

   logic [SAMPLE_W-1:0] mag;
   logic [SAMPLE_W-1:0] delayed;
   logic                capturing;
   logic                jump;

   onset_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
      .sample (sample_in),
      .mag    (mag)
   );

   onset_window_mean #(
      .MAG_W    (SAMPLE_W),
      .WIN_LOG2 (WIN_LOG2),
      .THR_W    (THR_W)
   ) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (sample_valid && !capturing),
      .mag   (mag),
      .thr   (threshold),
      .jump  (jump)
   );

   onset_delay_line #(
      .DATA_W     (SAMPLE_W),
      .DEPTH_LOG2 (WIN_LOG2)
   ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (sample_valid),
      .din   (sample_in),
      .dout  (delayed)
   );

   onset_capture #(
      .DATA_W      (SAMPLE_W),
      .CAPTURE_LEN (CAPTURE_LEN)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (jump),
      .step        (sample_valid),
      .din         (delayed),
      .active      (capturing),
      .word_valid  (word_valid),
      .word_sample (word_sample),
      .done        (capture_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) onset_pulse <= 1'b0;
      else        onset_pulse <= jump;
   end
endmodule

// File: rtl/onset_detector_checker.sv
module onset_detector_checker #(
   parameter int SAMPLE_W    = 8,
   parameter int WIN_LOG2    = 10,
   parameter int CAPTURE_LEN = 5120
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_valid,
   input logic                onset_pulse,
   input logic [SAMPLE_W-1:0] word_sample,
   input logic                word_valid,
   input logic                capture_done
);
   localparam int ARM_W = WIN_LOG2 + 2;
   localparam logic [ARM_W-1:0] ARM_MIN = ARM_W'(2) << WIN_LOG2;
   localparam int CAP_W = $clog2(CAPTURE_LEN + 1);

   logic [ARM_W-1:0] arm_cnt;
   logic [CAP_W-1:0] cap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_cnt <= '0;
         cap_cnt <= '0;
      end else begin
         if (capture_done)                       arm_cnt <= sample_valid ? ARM_W'(1) : '0;
         else if (sample_valid && arm_cnt < ARM_MIN) arm_cnt <= arm_cnt + 1'b1;
         if (onset_pulse)     cap_cnt <= '0;
         else if (word_valid) cap_cnt <= cap_cnt + 1'b1;
      end
   end

   a_r2_two_windows: assert property (@(posedge clk) disable iff (!rst_n)
      onset_pulse |-> (arm_cnt >= ARM_MIN));
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      onset_pulse |=> !onset_pulse);
   a_r6_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> (word_sample == '0));
   a_r7_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
      capture_done |-> word_valid);
   a_r7_exact_length: assert property (@(posedge clk) disable iff (!rst_n)
      capture_done |-> (cap_cnt == CAP_W'(CAPTURE_LEN - 1)));
   a_r8_no_onset_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> !onset_pulse);
   a_r9_quiet_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_valid |=> !(onset_pulse || word_valid || capture_done));
endmodule

bind onset_detector onset_detector_checker #(
   .SAMPLE_W    (SAMPLE_W),
   .WIN_LOG2    (WIN_LOG2),
   .CAPTURE_LEN (CAPTURE_LEN)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sample_valid (sample_valid),
   .onset_pulse  (onset_pulse),
   .word_sample  (word_sample),
   .word_valid   (word_valid),
   .capture_done (capture_done)
);

// File: tb/onset_detector_test.sv
module onset_detector_test;
   localparam int CLK_PERIOD = 10;
   localparam int L   = 3;
   localparam int N   = 1 << L;
   localparam int CAP = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sample_in = 8'd0;
   logic       sample_valid = 1'b0;
   logic [7:0] threshold = 8'd0;
   logic       onset_pulse;
   logic [7:0] word_sample;
   logic       word_valid;
   logic       capture_done;

   int nchk = 0;
   int nerr = 0;
   int onsets = 0;
   int dones = 0;
   int first_word = -1;
   bit first_pending = 1'b0;

   // bench model state
   logic [7:0] hist [0:16383];
   int  n_sent = 0;
   bit  m_cap = 1'b0;
   int  m_cnt = 0;
   int  m_phase = 0;
   int  m_sum = 0;
   bit  m_have = 1'b0;
   int  m_prev = 0;
   bit  e_on, e_wv, e_done;
   int  e_ws;

   always #(CLK_PERIOD/2) clk = ~clk;

   onset_detector #(
      .SAMPLE_W(8), .THR_W(8), .WIN_LOG2(L), .CAPTURE_LEN(CAP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .sample_valid(sample_valid),
      .threshold(threshold), .onset_pulse(onset_pulse), .word_sample(word_sample),
      .word_valid(word_valid), .capture_done(capture_done)
   );

   function automatic int amp_of(input int s);
      return (s >= 128) ? s - 128 : 128 - s;
   endfunction

   task automatic check_val(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic model_step(input int s);
      int mean;
      e_on = 1'b0; e_wv = 1'b0; e_done = 1'b0; e_ws = 0;
      if (m_cap) begin
         e_wv = 1'b1;
         e_ws = hist[n_sent - N];
         m_cnt++;
         if (m_cnt == CAP) begin
            e_done = 1'b1; m_cap = 1'b0;
            m_phase = 0; m_sum = 0; m_have = 1'b0;
         end
      end else begin
         m_sum += amp_of(s);
         m_phase++;
         if (m_phase == N) begin
            mean = m_sum >> L;
            if (m_have && mean > m_prev && (mean - m_prev) > int'(threshold)) begin
               e_on = 1'b1; m_cap = 1'b1; m_cnt = 0; m_have = 1'b0;
            end else begin
               m_have = 1'b1; m_prev = mean;
            end
            m_sum = 0; m_phase = 0;
         end
      end
      hist[n_sent] = s[7:0];
      n_sent++;
   endtask

   task automatic idle_cycle();
      @(negedge clk);
      check_val("R9 strobes low after idle", {29'd0, onset_pulse, word_valid, capture_done}, 0);
   endtask

   task automatic send(input int s);
      sample_in = s[7:0];
      sample_valid = 1'b1;
      model_step(s);
      @(negedge clk);
      sample_valid = 1'b0;
      sample_in = 8'h5A;
      check_val("R5 onset_pulse", onset_pulse, e_on);
      check_val("R6 word_valid", word_valid, e_wv);
      check_val("R6 word_sample", word_sample, e_wv ? e_ws : 0);
      check_val("R7 capture_done", capture_done, e_done);
      if (onset_pulse) begin onsets++; first_pending = 1'b1; end
      if (word_valid && first_pending) begin first_word = word_sample; first_pending = 1'b0; end
      if (capture_done) dones++;
      if (n_sent % 5 == 0) idle_cycle();
   endtask

   // window of constant amplitude, alternating sides of mid-scale
   task automatic send_amp(input int amp, input int count);
      for (int i = 0; i < count; i++) begin
         if (amp == 128 || i % 2 == 0) send(128 - amp);
         else                          send(128 + amp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check_val("R10 reset outputs", {20'd0, onset_pulse, word_valid, capture_done, word_sample}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_val("R10 first cycle after reset", {20'd0, onset_pulse, word_valid, capture_done, word_sample}, 0);

      // R2: loud first window after reset cannot trigger
      threshold = 8'd10;
      send_amp(100, N);
      check_val("R2 no onset on first window", onsets, 0);
      send_amp(100, N);
      send_amp(3, N);
      // R3: rise equal to threshold does not trigger
      send_amp(3, N);
      send_amp(13, N);
      check_val("R3 equal rise ignored", onsets, 0);
      send_amp(30, N);
      check_val("R3 rise above threshold", onsets, 1);
      // R8: loud window during capture flags nothing
      send_amp(0, N);
      send_amp(120, N);
      send_amp(0, CAP - 2 * N);
      check_val("R8 suspended during capture", onsets, 1);
      check_val("R7 one capture done", dones, 1);
      check_val("R6 first word is first sample of louder window", first_word, 98);
      // R8: re-arm needs two new windows
      send_amp(100, N);
      check_val("R8 rearm first window silent", onsets, 1);
      send_amp(100, N);

      // R4: windows do not overlap
      threshold = 8'd25;
      send_amp(0, N);
      send_amp(0, N / 2);
      send_amp(40, N / 2);
      send_amp(40, N);
      check_val("R4 no sliding detection", onsets, 1);
      send_amp(80, N);
      check_val("R4 boundary detection", onsets, 2);
      send_amp(0, CAP);
      check_val("R7 second capture done", dones, 2);

      // R3: zero threshold, falling and equal levels
      threshold = 8'd0;
      send_amp(60, N);
      send_amp(5, N);
      send_amp(5, N);
      check_val("R3 falling or equal ignored", onsets, 2);
      send_amp(6, N);
      check_val("R3 rise of one over zero", onsets, 3);
      send_amp(0, CAP);

      // R1: extremes of the amplitude range
      threshold = 8'd127;
      send_amp(0, N);
      for (int i = 0; i < N; i++) send(255);
      check_val("R1 full-scale high amplitude 127", onsets, 3);
      send_amp(0, N);
      send_amp(128, N);
      check_val("R1 zero sample amplitude 128", onsets, 4);
      send_amp(0, CAP);
      // R1: mean truncation
      threshold = 8'd0;
      send_amp(0, N);
      send(135); send_amp(0, N - 1);
      check_val("R1 truncated mean stays zero", onsets, 4);
      send(136); send_amp(0, N - 1);
      check_val("R1 mean reaches one", onsets, 5);
      send_amp(0, CAP);

      // sweep over thresholds and pseudo-random windows
      for (int p = 0; p < 4; p++) begin
         case (p)
            0: threshold = 8'd0;
            1: threshold = 8'd7;
            2: threshold = 8'd40;
            default: threshold = 8'd255;
         endcase
         for (int w = 0; w < 60; w++) begin
            int amp;
            amp = (w * 37 + p * 11) % 129;
            for (int i = 0; i < N; i++) begin
               if (i == 3)                          send((w * 53 + i * 17 + p) % 256);
               else if (amp == 128 || i % 2 == 0)   send(128 - amp);
               else                                 send(128 + amp);
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule